// File: doc/BRIEF.md
# Rate-trimmed nanosecond time-of-day counter

This block keeps a 64-bit time-of-day value in nanoseconds for a precision-time-protocol clock. It runs from a reference oscillator that is faster than the nominal clock it models. On every reference cycle a 32-bit fractional accumulator adds a programmable addend. Each carry out of that accumulator marks one nominal tick. On each tick the time value grows by a programmable period in nanoseconds, and a one-cycle strobe is raised.

Software picks the addend as the ceiling of 2^32 divided by the ratio of reference frequency to nominal frequency. That ratio must be above 1.0, so there is at most one carry per reference cycle. The nominal frequency in MHz is 1000 divided by the period. For example, a 125 MHz reference with a 10 ns period uses an addend of 0xCCCCCCCD. Small changes to the addend trim the clock rate while it runs. With a ratio of 1.25, the widest trim is 249,999,999 parts per billion.

A 2-bit clock-source code is kept in the control register and reported on a port. No clock is actually switched in this block.

Top module: `ptp_tod`

## Requirements
- R1: After reset, time_o is 0, tick_o is 0, src_sel_o is 0 and counting is disabled. The addend resets to 0xCCCCCCCD and the period resets to 10.
- R2: Writes use wr_addr_i as follows. Address 0 is control: bit 0 enables counting and bits 2:1 hold the source code. Address 1 is the addend. Address 2 is the period (low 16 bits). Address 3 stages the low 32 bits of a new time. Address 4 supplies the high 32 bits and performs the load. Writes to any other address change nothing.
- R3: While enabled, every cycle adds the addend to the accumulator. When the add carries, time_o grows by the period on that same edge and tick_o is high for exactly that following cycle.
- R4: Start from a cleared accumulator and run N enabled cycles with addend A. The number of ticks is then floor(N·A / 2^32), and time_o ends at the start value plus that count times the period.
- R5: While disabled, time_o and the accumulator keep their values and tick_o stays 0.
- R6: A write to address 4 sets time_o to {written data, staged low word} on that edge. The same write clears the accumulator, and tick_o is 0 in the following cycle.
- R7: An addend written while running is used from the next cycle onward. The accumulator value is kept, not reset.
- R8: A period written while running applies to the next tick.
- R9: src_sel_o reports the stored source code without changing the counting. The codes are: 0 external precision reference, 1 system clock, 2 transmit clock or reserved, 3 RTC oscillator.
- R10: At most one tick occurs per cycle. Each cycle, time_o either holds or grows by exactly one period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| time_o | output | 64 | Current time in nanoseconds |
| tick_o | output | 1 | Nominal-tick strobe |
| src_sel_o | output | 2 | Stored clock-source code |

## Verification
The hardest case to reach from the ports is a write that lands while the accumulator holds a non-zero fraction. The accumulator itself is never visible, so its state can only be inferred from when the next tick appears. The bench counts reference edges from the enabling write, so it knows the fraction at the moment of a time load, addend change or period change. It then checks that the next tick comes on the cycle predicted by a cleared accumulator (for a load) or by the kept one (for an addend change). For the kept case it picks addends whose sums give different tick counts if the fraction were lost.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_TXCK = 2'd2,
    SRC_RTC  = 2'd3
  } src_sel_e;

  typedef enum logic [2:0] {
    ADR_CTRL   = 3'd0,
    ADR_ADDEND = 3'd1,
    ADR_PERIOD = 3'd2,
    ADR_TLO    = 3'd3,
    ADR_THI    = 3'd4
  } reg_adr_e;

  typedef struct packed {
    src_sel_e src;
    logic     run;
  } ctrl_t;
endpackage

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
  import ptp_tod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 32,
  parameter int PER_W  = 16,
  parameter int TIME_W = 64,
  parameter logic [ACC_W-1:0] ADD_RST = 32'hCCCC_CCCD,
  parameter logic [PER_W-1:0] PER_RST = 16'd10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic [ACC_W-1:0]  addend_o,
  output logic [PER_W-1:0]  period_o,
  output logic              load_o,
  output logic [TIME_W-1:0] load_val_o
);
  localparam int HI_W = TIME_W - DATA_W;

  ctrl_t             ctrl_q;
  logic [ACC_W-1:0]  addend_q;
  logic [PER_W-1:0]  period_q;
  logic [DATA_W-1:0] tlo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '{src: SRC_EXT, run: 1'b0};
      addend_q <= ADD_RST;
      period_q <= PER_RST;
      tlo_q    <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADR_CTRL: begin
          ctrl_q.run <= wr_data_i[0];
          ctrl_q.src <= src_sel_e'(wr_data_i[2:1]);
        end
        ADR_ADDEND: addend_q <= wr_data_i[ACC_W-1:0];
        ADR_PERIOD: period_q <= wr_data_i[PER_W-1:0];
        ADR_TLO:    tlo_q    <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign ctrl_o     = ctrl_q;
  assign addend_o   = addend_q;
  assign period_o   = period_q;
  assign load_o     = wr_en_i && (wr_addr_i == ADR_THI);
  assign load_val_o = {wr_data_i[HI_W-1:0], tlo_q};
endmodule

// File: rtl/ptp_tod_phase.sv
module ptp_tod_phase #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic             carry_o,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             tick_q;

  assign sum     = {1'b0, acc_q} + {1'b0, addend_i};
  assign carry_o = run_i && !clr_i && sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= carry_o;
      if (clr_i)      acc_q <= '0;
      else if (run_i) acc_q <= sum[ACC_W-1:0];
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/ptp_tod_cnt.sv
module ptp_tod_cnt #(
  parameter int PER_W  = 16,
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic [PER_W-1:0]  period_i,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_q <= '0;
    else if (load_i) time_q <= load_val_i;
    else if (step_i) time_q <= time_q + TIME_W'(period_i);
  end

  assign time_o = time_q;
endmodule

// File: rtl/ptp_tod.sv
module ptp_tod
  import ptp_tod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 32,
  parameter int PER_W  = 16,
  parameter int TIME_W = 64,
  parameter logic [ACC_W-1:0] ADD_RST = 32'hCCCC_CCCD,
  parameter logic [PER_W-1:0] PER_RST = 16'd10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [TIME_W-1:0] time_o,
  output logic              tick_o,
  output logic [1:0]        src_sel_o
);
  ctrl_t             ctrl;
  logic [ACC_W-1:0]  addend;
  logic [PER_W-1:0]  period;
  logic              load_stb;
  logic [TIME_W-1:0] load_val;
  logic              carry;
  logic              run_q;

  ptp_tod_regs #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .PER_W(PER_W), .TIME_W(TIME_W),
    .ADD_RST(ADD_RST), .PER_RST(PER_RST)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .addend_o(addend), .period_o(period),
    .load_o(load_stb), .load_val_o(load_val)
  );

  assign run_q = ctrl.run;

  ptp_tod_phase #(.ACC_W(ACC_W)) u_phase (
    .clk_i, .rst_ni, .run_i(run_q), .clr_i(load_stb),
    .addend_i(addend), .carry_o(carry), .tick_o(tick_o)
  );

  ptp_tod_cnt #(.PER_W(PER_W), .TIME_W(TIME_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load_stb), .load_val_i(load_val),
    .step_i(carry), .period_i(period), .time_o(time_o)
  );

  assign src_sel_o = ctrl.src;
endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk #(
  parameter int PER_W  = 16,
  parameter int TIME_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              load_i,
  input logic [TIME_W-1:0] load_val_i,
  input logic [PER_W-1:0]  period_i,
  input logic [TIME_W-1:0] time_o,
  input logic              tick_o
);
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> ($stable(time_o) && !tick_o)); // R5

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(run_i)); // R5

  AST_LOAD_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (time_o == $past(load_val_i) && !tick_o)); // R6

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> (time_o == $past(time_o) ||
                            time_o == $past(time_o) + TIME_W'($past(period_i)))); // R10

  AST_TICK_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !$past(load_i)) |-> time_o == $past(time_o) + TIME_W'($past(period_i))); // R3
endmodule

bind ptp_tod ptp_tod_chk #(.PER_W(PER_W), .TIME_W(TIME_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .load_i(load_stb),
  .load_val_i(load_val), .period_i(period), .time_o(time_o), .tick_o(tick_o)
);

// File: tb/tb_ptp_tod.sv
module tb_ptp_tod;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] time_v;
  logic        tick;
  logic [1:0]  src_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ptp_tod dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .time_o(time_v), .tick_o(tick), .src_sel_o(src_sel)
  );

  typedef struct packed {
    logic [31:0] add;
    logic [15:0] per;
    logic [31:0] n;
    logic [63:0] start;
    logic [1:0]  src;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{add: 32'hCCCC_CCCD, per: 16'd10, n: 32'd100, start: 64'd0,                 src: 2'd0},
    '{add: 32'h8000_0000, per: 16'd8,  n: 32'd50,  start: 64'h0000_0001_0000_0000, src: 2'd1},
    '{add: 32'hFFFF_FFFF, per: 16'd1,  n: 32'd40,  start: 64'd5,                 src: 2'd3},
    '{add: 32'h4000_0000, per: 16'd5,  n: 32'd33,  start: 64'hFFFF_FFFF_FFFF_FF00, src: 2'd2},
    '{add: 32'h0000_0000, per: 16'd7,  n: 32'd20,  start: 64'd1234,              src: 2'd0},
    '{add: 32'hAAAA_AAAB, per: 16'd3,  n: 32'd61,  start: 64'h0000_0000_FFFF_FFF0, src: 2'd1}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  // write issued at current negedge; used by back-to-back sequences
  task automatic wr_now(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic load_time(logic [63:0] t);
    wr(3'd3, t[31:0]);
    wr(3'd4, t[63:32]);
  endtask

  // exactly n enabled reference edges (n >= 1)
  task automatic run_n(int n, logic [1:0] src);
    wr(3'd0, {29'd0, src, 1'b1});
    repeat (n - 1) @(negedge clk);
    wr_now(3'd0, {29'd0, src, 1'b0});
  endtask

  function automatic logic [63:0] ticks_of(logic [63:0] total);
    return total >> 32;
  endfunction

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp_t;
    logic [63:0] hold_t;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 time", time_v, 64'd0);
    check("R1 tick", {63'd0, tick}, 64'd0);
    check("R1 src", {62'd0, src_sel}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 disabled hold", time_v, 64'd0);
    // R1 default addend/period: 10 cycles of 0xCCCCCCCD, period 10
    run_n(10, 2'd0);
    @(negedge clk);
    check("R1 defaults", time_v, ticks_of(64'd10 * 64'hCCCC_CCCD) * 64'd10);

    // R4 table walk
    for (int i = 0; i < NV; i++) begin
      wr(3'd1, VECS[i].add);
      wr(3'd2, {16'd0, VECS[i].per});
      load_time(VECS[i].start);
      run_n(int'(VECS[i].n), VECS[i].src);
      @(negedge clk);
      exp_t = VECS[i].start +
              ticks_of({32'd0, VECS[i].add} * {32'd0, VECS[i].n}) * {48'd0, VECS[i].per};
      check("R4 vector", time_v, exp_t);
      check("R9 src kept", {62'd0, src_sel}, {62'd0, VECS[i].src});
    end

    // R5 hold while disabled
    hold_t = time_v;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (tick !== 1'b0) check("R5 tick idle", {63'd0, tick}, 64'd0);
    end
    check("R5 time hold", time_v, hold_t);

    // R2 unmapped address ignored
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R2 unmapped time", time_v, hold_t);
    check("R2 unmapped src", {62'd0, src_sel}, {62'd0, VECS[NV-1].src});

    // R3/R6 tick timing and load mid-run
    wr(3'd1, 32'h8000_0000);
    wr(3'd2, 32'd6);
    load_time(64'h100);
    wr(3'd3, 32'h0000_5000);
    wr(3'd0, 32'd1);
    @(negedge clk);
    check("R3 no tick first", {63'd0, tick}, 64'd0);
    @(negedge clk);
    check("R3 tick", {63'd0, tick}, 64'd1);
    check("R3 time step", time_v, 64'h106);
    @(negedge clk);
    check("R3 tick one cycle", {63'd0, tick}, 64'd0);
    wr_now(3'd4, 32'd2);
    check("R6 loaded", time_v, 64'h2_0000_5000);
    check("R6 tick low", {63'd0, tick}, 64'd0);
    @(negedge clk);
    check("R6 acc cleared", {63'd0, tick}, 64'd0);
    @(negedge clk);
    check("R6 first tick after load", time_v, 64'h2_0000_5006);
    wr_now(3'd0, 32'd0);

    // R7 addend change while running keeps fraction
    wr(3'd2, 32'd1);
    wr(3'd1, 32'h6000_0000);
    load_time(64'd0);
    wr(3'd0, 32'd1);
    repeat (2) @(negedge clk);
    wr_now(3'd1, 32'hF000_0000);
    @(negedge clk);
    wr_now(3'd0, 32'd0);
    @(negedge clk);
    check("R7 addend switch", time_v,
          ticks_of(64'd3 * 64'h6000_0000 + 64'd2 * 64'hF000_0000));

    // R8 period change applies to next tick
    wr(3'd1, 32'h8000_0000);
    wr(3'd2, 32'd4);
    load_time(64'd0);
    wr(3'd0, 32'd1);
    repeat (2) @(negedge clk);
    wr_now(3'd2, 32'd9);
    wr_now(3'd0, 32'd0);
    @(negedge clk);
    check("R8 period switch", time_v, 64'd13);

    // R9 source code only reported
    hold_t = time_v;
    wr(3'd0, 32'h6);
    @(negedge clk);
    check("R9 src rtc", {62'd0, src_sel}, 64'd3);
    check("R9 no count", time_v, hold_t);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule